// File: doc/BRIEF.md
# Integer Execute Unit with Shifter

This block is the purely combinational arithmetic stage of a 32-bit integer pipeline. Each cycle it receives a 5-bit operation code, two register operands and a 16-bit immediate. It returns one 32-bit result and a flag that marks a division by zero. The unit handles the following operation families:

- add and subtract
- low-word multiply
- signed and unsigned quotient and remainder
- bitwise AND, OR, XOR and XNOR
- left, logical-right and arithmetic-right shifts
- placing an immediate in the upper half of a word

The operation code picks between a register form and an immediate form. For an immediate form, the unit itself decides whether the immediate is sign-extended or zero-extended. When the divide flag is high the result carries no meaning, and the surrounding pipeline must drop the register write and take the exception. Register-file access, memory access and control flow are not part of this block.

Top module: `int_exec_alu`

## Requirements
- R1: The operation code is 5 bits wide. Bit 0 set selects an immediate form, which ignores `opnd_b_i`. Bit 0 clear selects a register form, which ignores `imm_i`. The code values are:
  - 0 add, 1 add-imm
  - 2 sub, 3 sub-imm
  - 4 mul, 5 mul-imm
  - 6 mul-unsigned, 7 mul-unsigned-imm
  - 8 div, 9 div-imm
  - 10 div-unsigned, 11 div-unsigned-imm
  - 12 rem, 13 rem-imm
  - 14 rem-unsigned, 15 rem-unsigned-imm
  - 16 and, 17 and-imm
  - 18 or, 19 or-imm
  - 20 xor, 21 xor-imm
  - 22 xnor, 23 xnor-imm
  - 24 shift-left, 25 shift-left-imm
  - 26 shift-right-logical, 27 shift-right-logical-imm
  - 28 shift-right-arith, 29 shift-right-arith-imm
  - 30 reserved, which gives result 0 and a clear flag
  - 31 load-high-immediate
- R2: Codes 1, 3, 5, 9 and 13 sign-extend the immediate. Codes 7, 11, 15, 17, 19, 21 and 23 zero-extend it.
- R3: Add, subtract and both multiply kinds return their result modulo 2^32. A multiply returns the low 32 bits of the product.
- R4: Every shift uses only bits 4:0 of its count, whether the count comes from the register operand or from the immediate.
- R5: A logical right shift fills the vacated bits with zeros. An arithmetic right shift fills them with copies of operand A bit 31.
- R6: Load-high-immediate returns the immediate in bits 31:16 and zeros in bits 15:0.
- R7: AND, OR and XOR are bitwise. XNOR returns the complement of XOR.
- R8: `div_zero_o` is high exactly when the operation is one of the eight quotient or remainder codes (8 to 15) and the divisor is zero after extension. For every other code the flag is low.
- R9: A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend. The case -2^31 divided by -1 gives quotient 0x80000000 and remainder 0.
- R10: An unsigned quotient and remainder treat both operands as unsigned 32-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see R1) |
| opnd_a_i | input | 32 | First operand, also the dividend and the value that is shifted |
| opnd_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Operation result |
| div_zero_o | output | 1 | Divide-by-zero exception flag |

## Verification
The sweeps cross every operation code with a set of extreme operands: zero, all-ones, the most negative value, the largest positive value, small signed values, and shift counts above 31.

- A design that extended the immediate the wrong way would return wrong results for immediates with bit 15 set.
- A design that used a sixth count bit would shift a register count of 37 by 37 instead of by 5.
- A design that filled arithmetic shifts with zeros would lose the sign of negative operands.
- A signed divider built on a native operator could fail on -2^31 / -1. A divider that rounded toward minus infinity would get -7 / 2 wrong.

A long stretch of random vectors also runs the immediate forms with random `opnd_b_i` values, so that any leak of the register operand into an immediate form becomes visible.

// File: rtl/exu_pkg.sv
package exu_pkg;

   typedef enum logic [4:0] {
      EXU_ADD   = 5'd0,  EXU_ADDI  = 5'd1,
      EXU_SUB   = 5'd2,  EXU_SUBI  = 5'd3,
      EXU_MUL   = 5'd4,  EXU_MULI  = 5'd5,
      EXU_MULU  = 5'd6,  EXU_MULUI = 5'd7,
      EXU_DIV   = 5'd8,  EXU_DIVI  = 5'd9,
      EXU_DIVU  = 5'd10, EXU_DIVUI = 5'd11,
      EXU_REM   = 5'd12, EXU_REMI  = 5'd13,
      EXU_REMU  = 5'd14, EXU_REMUI = 5'd15,
      EXU_AND   = 5'd16, EXU_ANDI  = 5'd17,
      EXU_OR    = 5'd18, EXU_ORI   = 5'd19,
      EXU_XOR   = 5'd20, EXU_XORI  = 5'd21,
      EXU_XNOR  = 5'd22, EXU_XNORI = 5'd23,
      EXU_SLL   = 5'd24, EXU_SLLI  = 5'd25,
      EXU_SRL   = 5'd26, EXU_SRLI  = 5'd27,
      EXU_SRA   = 5'd28, EXU_SRAI  = 5'd29,
      EXU_RSVD  = 5'd30, EXU_LDHI  = 5'd31
   } exu_op_e;

   typedef enum logic [1:0] {
      SHK_LEFT  = 2'd0,
      SHK_RLOG  = 2'd1,
      SHK_RARI  = 2'd2
   } shift_kind_e;

   // Immediate forms occupy the odd codes.
   function automatic logic op_uses_imm(exu_op_e op);
      return op[0];
   endfunction

   function automatic logic op_imm_signed(exu_op_e op);
      return (op == EXU_ADDI) || (op == EXU_SUBI) || (op == EXU_MULI) ||
             (op == EXU_DIVI) || (op == EXU_REMI);
   endfunction

   // Quotient and remainder family sits at codes 8..15.
   function automatic logic op_is_divide(exu_op_e op);
      return op[4:3] == 2'b01;
   endfunction

endpackage

// File: rtl/exu_opnd_sel.sv
module exu_opnd_sel
   import exu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IMM_W = 16
) (
   input  exu_op_e            op_i,
   input  logic [WIDTH-1:0]   reg_b_i,
   input  logic [IMM_W-1:0]   imm_i,
   output logic [WIDTH-1:0]   opnd_o
);

   localparam int EXT_W = WIDTH - IMM_W;

   logic [WIDTH-1:0] imm_sext;
   logic [WIDTH-1:0] imm_zext;

   generate
      if (EXT_W > 0) begin : g_ext
         assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
         assign imm_zext = {{EXT_W{1'b0}}, imm_i};
      end else begin : g_noext
         assign imm_sext = imm_i[WIDTH-1:0];
         assign imm_zext = imm_i[WIDTH-1:0];
      end
   endgenerate

   always_comb begin
      if (!op_uses_imm(op_i))     opnd_o = reg_b_i;
      else if (op_imm_signed(op_i)) opnd_o = imm_sext;
      else                        opnd_o = imm_zext;
   end

   always_comb begin
      if (!$isunknown({op_i, imm_i, reg_b_i}) && op_uses_imm(op_i)) begin
         assert_imm_low_R2: assert (opnd_o[IMM_W-1:0] == imm_i)
            else $error("immediate low field not carried");
         if (!op_imm_signed(op_i) && EXT_W > 0)
            assert_zext_upper_R2: assert (opnd_o[WIDTH-1:IMM_W] == '0)
               else $error("zero-extended immediate has upper bits set");
      end
   end

endmodule

// File: rtl/exu_shift.sv
module exu_shift
   import exu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit STAGED = 1'b1
) (
   input  shift_kind_e              kind_i,
   input  logic [WIDTH-1:0]         data_i,
   input  logic [$clog2(WIDTH)-1:0] cnt_i,
   output logic [WIDTH-1:0]         data_o
);

   localparam int SH_W = $clog2(WIDTH);

   function automatic logic [WIDTH-1:0] bit_rev(logic [WIDTH-1:0] v);
      logic [WIDTH-1:0] r;
      for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
      return r;
   endfunction

   generate
      if (STAGED) begin : g_staged
         logic             is_left;
         logic             fill;
         logic [WIDTH-1:0] stage [0:SH_W];

         assign is_left  = (kind_i == SHK_LEFT);
         assign fill     = (kind_i == SHK_RARI) & data_i[WIDTH-1];
         assign stage[0] = is_left ? bit_rev(data_i) : data_i;

         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = cnt_i[k]
               ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
               : stage[k];
         end

         assign data_o = is_left ? bit_rev(stage[SH_W]) : stage[SH_W];
      end else begin : g_operator
         always_comb begin
            unique case (kind_i)
               SHK_LEFT: data_o = data_i << cnt_i;
               SHK_RARI: data_o = WIDTH'($signed(data_i) >>> cnt_i);
               default:  data_o = data_i >> cnt_i;
            endcase
         end
      end
   endgenerate

   always_comb begin
      if (!$isunknown({kind_i, data_i, cnt_i})) begin
         if (kind_i == SHK_RARI && data_i[WIDTH-1])
            assert_sra_fill_R5: assert (data_o[WIDTH-1])
               else $error("arithmetic shift lost sign bit");
         if (kind_i == SHK_RLOG && cnt_i != '0)
            assert_srl_zero_R5: assert (!data_o[WIDTH-1])
               else $error("logical shift filled with ones");
      end
   end

endmodule

// File: rtl/exu_muldiv.sv
module exu_muldiv #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             signed_i,
   output logic [WIDTH-1:0] prod_o,
   output logic [WIDTH-1:0] quot_o,
   output logic [WIDTH-1:0] rem_o,
   output logic             b_zero_o
);

   logic             neg_a, neg_b;
   logic [WIDTH-1:0] mag_a, mag_b, safe_b;
   logic [WIDTH-1:0] uq, ur;

   assign prod_o   = a_i * b_i;
   assign b_zero_o = (b_i == '0);

   assign neg_a  = signed_i & a_i[WIDTH-1];
   assign neg_b  = signed_i & b_i[WIDTH-1];
   assign mag_a  = neg_a ? (~a_i + 1'b1) : a_i;
   assign mag_b  = neg_b ? (~b_i + 1'b1) : b_i;
   // A zero divisor is replaced so the dividers never see it; result is unused.
   assign safe_b = b_zero_o ? {{(WIDTH-1){1'b0}}, 1'b1} : mag_b;
   assign uq     = mag_a / safe_b;
   assign ur     = mag_a % safe_b;
   assign quot_o = (neg_a ^ neg_b) ? (~uq + 1'b1) : uq;
   assign rem_o  = neg_a ? (~ur + 1'b1) : ur;

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
   import exu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int IMM_W        = 16,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [4:0]        op_i,
   input  logic [WIDTH-1:0]  opnd_a_i,
   input  logic [WIDTH-1:0]  opnd_b_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [WIDTH-1:0]  result_o,
   output logic              div_zero_o
);

   localparam int SH_W = $clog2(WIDTH);
   localparam int LO_W = WIDTH - IMM_W;

   generate
      if (WIDTH < IMM_W || LO_W < 1) begin : g_bad_imm
         $error("WIDTH must exceed IMM_W");
      end
      if ((1 << SH_W) != WIDTH) begin : g_bad_width
         $error("WIDTH must be a power of two");
      end
   endgenerate

   exu_op_e          op;
   logic [WIDTH-1:0] opnd_b;
   logic [WIDTH-1:0] prod, quot, rem, shifted;
   logic             b_zero;
   logic             div_signed;
   shift_kind_e      sh_kind;

   assign op = exu_op_e'(op_i);

   exu_opnd_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opnd_sel (
      .op_i    (op),
      .reg_b_i (opnd_b_i),
      .imm_i   (imm_i),
      .opnd_o  (opnd_b)
   );

   // Codes 8,9,12,13 are the signed quotient/remainder forms.
   assign div_signed = ~op[1];

   exu_muldiv #(.WIDTH(WIDTH)) u_muldiv (
      .a_i      (opnd_a_i),
      .b_i      (opnd_b),
      .signed_i (div_signed),
      .prod_o   (prod),
      .quot_o   (quot),
      .rem_o    (rem),
      .b_zero_o (b_zero)
   );

   always_comb begin
      unique case (op_i[2:1])
         2'b00:   sh_kind = SHK_LEFT;
         2'b01:   sh_kind = SHK_RLOG;
         default: sh_kind = SHK_RARI;
      endcase
   end

   exu_shift #(.WIDTH(WIDTH), .STAGED(SHIFT_STAGED)) u_shift (
      .kind_i (sh_kind),
      .data_i (opnd_a_i),
      .cnt_i  (opnd_b[SH_W-1:0]),
      .data_o (shifted)
   );

   assign div_zero_o = op_is_divide(op) & b_zero;

   always_comb begin
      case (op)
         EXU_ADD,  EXU_ADDI:  result_o = opnd_a_i + opnd_b;
         EXU_SUB,  EXU_SUBI:  result_o = opnd_a_i - opnd_b;
         EXU_MUL,  EXU_MULI,
         EXU_MULU, EXU_MULUI: result_o = prod;
         EXU_DIV,  EXU_DIVI,
         EXU_DIVU, EXU_DIVUI: result_o = quot;
         EXU_REM,  EXU_REMI,
         EXU_REMU, EXU_REMUI: result_o = rem;
         EXU_AND,  EXU_ANDI:  result_o = opnd_a_i & opnd_b;
         EXU_OR,   EXU_ORI:   result_o = opnd_a_i | opnd_b;
         EXU_XOR,  EXU_XORI:  result_o = opnd_a_i ^ opnd_b;
         EXU_XNOR, EXU_XNORI: result_o = ~(opnd_a_i ^ opnd_b);
         EXU_SLL,  EXU_SLLI,
         EXU_SRL,  EXU_SRLI,
         EXU_SRA,  EXU_SRAI:  result_o = shifted;
         EXU_LDHI:            result_o = {imm_i, {LO_W{1'b0}}};
         default:             result_o = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({op_i, opnd_a_i, opnd_b_i, imm_i})) begin
         if (div_zero_o)
            assert_flag_div_only_R8: assert (op_i[4:3] == 2'b01 && opnd_b == '0)
               else $error("divide flag outside a zero-divisor divide");
         if (op == EXU_LDHI)
            assert_ldhi_low_R6: assert (result_o[LO_W-1:0] == '0)
               else $error("load-high low half not zero");
         if (op == EXU_XNOR)
            assert_xnor_parity_R7: assert (result_o != (opnd_a_i ^ opnd_b_i))
               else $error("xnor equals xor");
         if (op == EXU_RSVD)
            assert_rsvd_quiet_R1: assert (result_o == '0 && !div_zero_o)
               else $error("reserved code produced output");
      end
   end

endmodule

// File: tb/int_exec_alu_bench.sv
module int_exec_alu_bench;
   import exu_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op;
   logic [31:0] a, b, res;
   logic [15:0] imm;
   logic        dz;
   int          checks = 0;
   int          errors = 0;
   int          cycles = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   int_exec_alu u_int_exec_alu (
      .op_i(op), .opnd_a_i(a), .opnd_b_i(b), .imm_i(imm),
      .result_o(res), .div_zero_o(dz)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] ext_b(logic [4:0] o, logic [31:0] rb, logic [15:0] im);
      if (!o[0]) return rb;
      if (o == 5'd1 || o == 5'd3 || o == 5'd5 || o == 5'd9 || o == 5'd13)
         return {{16{im[15]}}, im};
      return {16'h0, im};
   endfunction

   function automatic logic [31:0] model(logic [4:0] o, logic [31:0] x,
                                         logic [31:0] rb, logic [15:0] im);
      logic [31:0] y;
      longint sx, sy;
      logic [63:0] ux, uy;
      int n;
      y  = ext_b(o, rb, im);
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      ux = {32'h0, x};
      uy = {32'h0, y};
      n  = int'(y[4:0]);
      case (o >> 1)
         5'd0: return x + y;
         5'd1: return x - y;
         5'd2, 5'd3: return 32'(ux * uy);
         5'd4: return 32'(sx / sy);
         5'd5: return 32'(ux / uy);
         5'd6: return 32'(sx % sy);
         5'd7: return 32'(ux % uy);
         5'd8: return x & y;
         5'd9: return x | y;
         5'd10: return x ^ y;
         5'd11: return ~(x ^ y);
         5'd12: return 32'(ux << n);
         5'd13: return 32'(ux >> n);
         5'd14: return 32'(sx >> n);
         default: return (o == 5'd31) ? {im, 16'h0} : 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [4:0] o);
      case (o >> 1)
         5'd0, 5'd1, 5'd2, 5'd3: return o[0] ? "R2/R3" : "R3";
         5'd4, 5'd6: return "R9";
         5'd5, 5'd7: return "R10";
         5'd8, 5'd9, 5'd10, 5'd11: return o[0] ? "R2/R7" : "R7";
         5'd12: return "R4";
         5'd13, 5'd14: return "R5";
         default: return (o == 5'd31) ? "R6" : "R1";
      endcase
   endfunction

   task automatic apply(logic [4:0] o, logic [31:0] x, logic [31:0] rb, logic [15:0] im);
      logic [31:0] exp_r;
      logic        exp_z;
      @(posedge clk);
      op = o; a = x; b = rb; imm = im;
      @(negedge clk);
      exp_z = (o >= 5'd8 && o <= 5'd15) && (ext_b(o, rb, im) == 32'h0);
      checks = checks + 1;
      if (dz !== exp_z) begin
         errors = errors + 1;
         $display("FAIL R8 op=%0d a=%h b=%h imm=%h flag=%b exp=%b", o, x, rb, im, dz, exp_z);
      end
      if (!exp_z) begin
         exp_r = model(o, x, rb, im);
         checks = checks + 1;
         if (res !== exp_r) begin
            errors = errors + 1;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h got=%h exp=%h",
                     tag_of(o), o, x, rb, im, res, exp_r);
         end
      end
   endtask

   function automatic logic [31:0] xs32(logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      return t ^ (t << 5);
   endfunction

   logic [31:0] corner [8];
   logic [15:0] imms   [4];

   initial begin
      logic [31:0] seed;
      corner[0] = 32'h0;        corner[1] = 32'h1;
      corner[2] = 32'hFFFFFFFF; corner[3] = 32'h80000000;
      corner[4] = 32'h7FFFFFFF; corner[5] = 32'h7;
      corner[6] = 32'hFFFFFFF9; corner[7] = 32'h25;  // count 37 -> 5 (R4)
      imms[0] = 16'h0000; imms[1] = 16'h0003;
      imms[2] = 16'hFFF9; imms[3] = 16'h8025;
      op = 5'd0; a = 32'h0; b = 32'h0; imm = 16'h0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Idle input state: add of zeros gives zero, no flag (R3, R8).
      @(negedge clk);
      checks = checks + 1;
      if (res !== 32'h0 || dz !== 1'b0) begin
         errors = errors + 1;
         $display("FAIL R3 idle res=%h dz=%b exp=0 0", res, dz);
      end
      // Sweep all codes over corner operands and immediates (R1..R10).
      for (int o = 0; o < 32; o++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               for (int k = 0; k < 4; k++)
                  apply(5'(o), corner[i], corner[j], imms[k]);
      // Random vectors, random register B for immediate forms checks R1 isolation.
      seed = 32'h1234ABCD;
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] x, y, z;
         seed = xs32(seed); x = seed;
         seed = xs32(seed); y = seed;
         seed = xs32(seed); z = seed;
         if (z[7]) y = y & 32'h0000_000F;
         apply(z[4:0], x, y, z[31:16]);
      end
      // Signed overflow divide and sign rules (R9).
      apply(5'd8,  32'h80000000, 32'hFFFFFFFF, 16'h0);
      apply(5'd12, 32'h80000000, 32'hFFFFFFFF, 16'h0);
      apply(5'd9,  32'hFFFFFFF9, 32'h0, 16'h0002);
      apply(5'd13, 32'hFFFFFFF9, 32'h0, 16'h0002);
      // Zero divisor on unsigned immediate form (R8).
      apply(5'd11, 32'h1234, 32'h5, 16'h0000);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule